// File: doc/BRIEF.md
# I2C Controller Format-Command Sequencer

This block sits between a queue of byte-plus-flag commands and a bit-level I2C engine. It takes one 13-bit entry at a time from the format queue. It splits the entry into the byte-level primitives the engine understands: start or repeated start, write one byte and report the acknowledge, read one byte with a chosen acknowledge, and stop. Software builds whole transactions out of a handful of such entries. When the read flag is set, the byte field is a transfer length rather than data.

Bytes read from the target go straight into the receive queue. A write that is not acknowledged, a lost arbitration or a bus timeout halts the sequencer. The cause is kept in sticky halt bits, and software clears them with a write-one-to-clear mask. After every halt bit is clear, the sequencer continues with the next queued entry. If software leaves a NACK halt in place for too long, a watchdog flags it. Two level-compare outputs give watermark interrupts for the receive queue and the format queue.

Top module: `i2c_fmt_sequencer`

## Requirements
- R1: The entry layout is: bits [7:0] byte, bit 8 start, bit 9 stop, bit 10 read, bit 11 read-continue, bit 12 NACK-suppress. The command codes on `cmd_op` are 0 start, 1 repeated start, 2 write, 3 read and 4 stop. An entry with start set first issues code 0, or code 1 when an earlier start in the same transaction has not yet been closed by a stop or a halt.
- R2: An entry without the read flag writes its byte with code 2, after any start. When stop is set, code 4 follows once the byte has been acknowledged.
- R3: An entry with the read flag issues as many code-3 commands as its byte value, and 0 stands for 256. Each completed read pulses `rx_push` with the returned byte on `rx_data`.
- R4: `cmd_ack` is 1 (ACK) for every read except the last one of an entry. The last read carries 0 (NACK) unless read-continue is set, in which case it carries 1. Stop is issued after the last read only when the stop flag is set.
- R5: An entry is illegal when stop, read and read-continue are all set, or when NACK-suppress is set together with read or read-continue. An illegal entry is popped, pulses `illegal_err` for one cycle and issues no command.
- R6: A write that ends with `eng_nack`=1 and NACK-suppress clear sets halt bit 2 and issues no stop. No further entry is popped while any halt bit is set. With NACK-suppress set, the NACK is ignored and the entry completes normally.
- R7: `halt_events` holds sticky bits: 0 arbitration lost, 1 bus timeout, 2 NACK received, 3 unhandled-NACK timeout. A pulse on `eng_arb_lost` or `eng_bus_timeout` while a command is pending or outstanding sets bit 0 or bit 1 and halts the sequencer. Each 1 in `halt_clear` clears only its own bit. The sequencer resumes only after all bits are 0.
- R8: If bit 2 stays set for `nack_wait_limit` cycles (a limit of 0 disables the check), bit 3 is set.
- R9: One cycle after the inputs change, `irq_rx_wm` is 1 exactly when `rx_level` > `rx_thresh`, and `irq_fmt_wm` is 1 exactly when `fmt_level` < `fmt_thresh`.
- R10: When `enable` is 0, no entry is popped. `host_idle` is 1 while the sequencer has no entry in progress and the format queue is empty.
- R11: No read command is presented while `rx_full` is 1. The read waits until space is available.
- R12: Once `cmd_valid` is raised, it stays high with unchanged `cmd_op` and `cmd_data` until `cmd_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows entries to be consumed |
| fmt_valid | input | 1 | Format queue holds an entry |
| fmt_entry | input | 13 | Head entry of the format queue |
| fmt_level | input | LVL_W | Format queue fill level |
| fmt_pop | output | 1 | Removes the head entry |
| cmd_valid | output | 1 | Primitive command offered to the bit engine |
| cmd_ready | input | 1 | Bit engine accepts the command |
| cmd_op | output | 3 | Primitive command code |
| cmd_data | output | 8 | Byte to write |
| cmd_ack | output | 1 | Acknowledge to drive after a read byte (1 = ACK) |
| eng_done | input | 1 | Accepted command has finished |
| eng_nack | input | 1 | Write was not acknowledged (valid with eng_done) |
| eng_rdata | input | 8 | Read byte (valid with eng_done) |
| eng_arb_lost | input | 1 | Engine reports lost arbitration |
| eng_bus_timeout | input | 1 | Engine reports a bus timeout |
| rx_full | input | 1 | Receive queue has no space |
| rx_level | input | LVL_W | Receive queue fill level |
| rx_push | output | 1 | Write strobe into the receive queue |
| rx_data | output | 8 | Byte for the receive queue |
| halt_events | output | 4 | Sticky halt causes |
| halt_clear | input | 4 | Write-one-to-clear mask for halt causes |
| nack_wait_limit | input | WDOG_W | Cycles allowed for software to handle a NACK |
| rx_thresh | input | LVL_W | Receive watermark threshold |
| fmt_thresh | input | LVL_W | Format watermark threshold |
| irq_rx_wm | output | 1 | Receive level above threshold |
| irq_fmt_wm | output | 1 | Format level below threshold |
| illegal_err | output | 1 | One-cycle pulse for a discarded illegal entry |
| host_idle | output | 1 | Nothing in progress and format queue empty |

## Verification
The assertions assume that the bit engine pulses `eng_done` only after accepting a command, and that `rx_full` never rises while a read is being offered. They also assume that `eng_arb_lost` and `eng_bus_timeout` arrive only while a command is pending or running. The bench's engine model reports completion only after a handshake has finished. It changes `rx_full` only while the sequencer is between commands, and it pulses the fault inputs only while a write is outstanding. The format queue model always presents a stable head entry until that entry is popped.

// File: rtl/i2c_fmt_pkg.sv
package i2c_fmt_pkg;

    localparam int BYTE_W  = 8;
    localparam int ENTRY_W = BYTE_W + 5;
    localparam int CNT_W   = BYTE_W + 1;
    localparam int HALT_W  = 4;

    localparam int HB_ARB  = 0;
    localparam int HB_TMO  = 1;
    localparam int HB_NACK = 2;
    localparam int HB_NTMO = 3;

    typedef struct packed {
        logic              nak_ok;
        logic              rd_cont;
        logic              rd;
        logic              stop;
        logic              start;
        logic [BYTE_W-1:0] data;
    } fmt_entry_t;

    typedef enum logic [2:0] {
        OP_START  = 3'd0,
        OP_RSTART = 3'd1,
        OP_WRITE  = 3'd2,
        OP_READ   = 3'd3,
        OP_STOP   = 3'd4
    } bus_op_e;

    typedef enum logic [1:0] {PH_START, PH_WRITE, PH_READ, PH_STOP} phase_e;
    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_HALT} seq_state_e;

    function automatic logic entry_illegal(fmt_entry_t e);
        return (e.stop && e.rd && e.rd_cont) || (e.nak_ok && (e.rd || e.rd_cont));
    endfunction

    function automatic logic [CNT_W-1:0] read_len(logic [BYTE_W-1:0] b);
        return (b == '0) ? CNT_W'(1 << BYTE_W) : CNT_W'(b);
    endfunction

endpackage

// File: rtl/i2c_fmt_decode.sv
module i2c_fmt_decode
    import i2c_fmt_pkg::*;
(
    input  logic [ENTRY_W-1:0] raw,
    output logic               illegal,
    output phase_e             first_ph,
    output logic [CNT_W-1:0]   len,
    output logic [BYTE_W-1:0]  data,
    output logic               stop,
    output logic               rd,
    output logic               rd_cont,
    output logic               nak_ok
);
    fmt_entry_t e;

    always_comb begin
        e        = fmt_entry_t'(raw);
        illegal  = entry_illegal(e);
        len      = read_len(e.data);
        data     = e.data;
        stop     = e.stop;
        rd       = e.rd;
        rd_cont  = e.rd_cont;
        nak_ok   = e.nak_ok;
        if (e.start)   first_ph = PH_START;
        else if (e.rd) first_ph = PH_READ;
        else           first_ph = PH_WRITE;
    end
endmodule

// File: rtl/i2c_fmt_halt.sv
module i2c_fmt_halt
    import i2c_fmt_pkg::*;
#(
    parameter int WDOG_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_arb,
    input  logic              set_tmo,
    input  logic              set_nack,
    input  logic [HALT_W-1:0] clr_mask,
    input  logic [WDOG_W-1:0] wd_limit,
    output logic [HALT_W-1:0] halt_q
);
    logic [WDOG_W-1:0] wd_cnt;
    logic              wd_run;
    logic              wd_fire;
    logic [HALT_W-1:0] set_vec;

    assign wd_run  = halt_q[HB_NACK] && !halt_q[HB_NTMO] && (wd_limit != '0);
    assign wd_fire = wd_run && (wd_cnt == wd_limit - WDOG_W'(1));

    always_comb begin
        set_vec          = '0;
        set_vec[HB_ARB]  = set_arb;
        set_vec[HB_TMO]  = set_tmo;
        set_vec[HB_NACK] = set_nack;
        set_vec[HB_NTMO] = wd_fire;
    end

    for (genvar i = 0; i < HALT_W; i++) begin : g_sticky
        always_ff @(posedge clk) begin
            if (rst)             halt_q[i] <= 1'b0;
            else if (set_vec[i]) halt_q[i] <= 1'b1;
            else if (clr_mask[i]) halt_q[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !wd_run || wd_fire) wd_cnt <= '0;
        else                           wd_cnt <= wd_cnt + WDOG_W'(1);
    end

    // R7: a bit that was set and not cleared stays set
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((halt_q & $past(halt_q & ~clr_mask)) == $past(halt_q & ~clr_mask)));

    // R8: the timeout bit only rises on top of an outstanding NACK
    a_r8_ntmo_after_nack: assert property (@(posedge clk) disable iff (rst)
        $rose(halt_q[HB_NTMO]) |-> halt_q[HB_NACK] || $past(halt_q[HB_NACK]));
endmodule

// File: rtl/i2c_fmt_wmark.sv
module i2c_fmt_wmark #(
    parameter int LVL_W = 7,
    parameter bit ABOVE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] thresh,
    output logic             irq
);
    logic hit;

    if (ABOVE) begin : g_above
        assign hit = level > thresh;
    end else begin : g_below
        assign hit = level < thresh;
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= hit;
    end

    // R9: the interrupt never rises without the level crossing its threshold
    a_r9_level_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (ABOVE ? ($past(level) > $past(thresh)) : ($past(level) < $past(thresh))));
endmodule

// File: rtl/i2c_fmt_fsm.sv
module i2c_fmt_fsm
    import i2c_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              fmt_valid,
    input  logic              illegal,
    input  phase_e            first_ph,
    input  logic [CNT_W-1:0]  len,
    input  logic [BYTE_W-1:0] e_data,
    input  logic              e_stop,
    input  logic              e_rd,
    input  logic              e_rd_cont,
    input  logic              e_nak_ok,
    input  logic              halted,
    input  logic              eng_fault,
    output logic              fmt_pop,
    output logic              illegal_err,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output bus_op_e           cmd_op,
    output logic [BYTE_W-1:0] cmd_data,
    output logic              cmd_ack,
    input  logic              eng_done,
    input  logic              eng_nack,
    input  logic [BYTE_W-1:0] eng_rdata,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_data,
    output logic              nack_set,
    output logic              host_idle
);
    seq_state_e        state;
    phase_e            ph;
    logic [CNT_W-1:0]  remain;
    logic [BYTE_W-1:0] cur_data;
    logic              cur_stop, cur_rd, cur_rd_cont, cur_nak_ok;
    logic              in_txn;
    logic              last_rd;

    assign last_rd     = (remain == CNT_W'(1));
    assign fmt_pop     = (state == ST_IDLE) && enable && fmt_valid && !halted;
    assign illegal_err = fmt_pop && illegal;
    assign cmd_valid   = (state == ST_ISSUE) && !((ph == PH_READ) && rx_full);
    assign cmd_data    = cur_data;
    assign cmd_ack     = !last_rd || cur_rd_cont;
    assign rx_push     = (state == ST_WAIT) && (ph == PH_READ) && eng_done;
    assign rx_data     = eng_rdata;
    assign nack_set    = (state == ST_WAIT) && (ph == PH_WRITE) && eng_done
                         && eng_nack && !cur_nak_ok;
    assign host_idle   = (state == ST_IDLE) && !fmt_valid;

    always_comb begin
        case (ph)
            PH_START: cmd_op = in_txn ? OP_RSTART : OP_START;
            PH_WRITE: cmd_op = OP_WRITE;
            PH_READ:  cmd_op = OP_READ;
            default:  cmd_op = OP_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            ph          <= PH_START;
            remain      <= '0;
            cur_data    <= '0;
            cur_stop    <= 1'b0;
            cur_rd      <= 1'b0;
            cur_rd_cont <= 1'b0;
            cur_nak_ok  <= 1'b0;
            in_txn      <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (fmt_pop && !illegal) begin
                    state       <= ST_ISSUE;
                    ph          <= first_ph;
                    remain      <= len;
                    cur_data    <= e_data;
                    cur_stop    <= e_stop;
                    cur_rd      <= e_rd;
                    cur_rd_cont <= e_rd_cont;
                    cur_nak_ok  <= e_nak_ok;
                end
                ST_ISSUE: begin
                    if (eng_fault) begin
                        state  <= ST_HALT;
                        in_txn <= 1'b0;
                    end else if (cmd_valid && cmd_ready) begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (eng_fault) begin
                        state  <= ST_HALT;
                        in_txn <= 1'b0;
                    end else if (eng_done) begin
                        case (ph)
                            PH_START: begin
                                in_txn <= 1'b1;
                                ph     <= cur_rd ? PH_READ : PH_WRITE;
                                state  <= ST_ISSUE;
                            end
                            PH_WRITE: begin
                                if (nack_set) begin
                                    state  <= ST_HALT;
                                    in_txn <= 1'b0;
                                end else if (cur_stop) begin
                                    ph    <= PH_STOP;
                                    state <= ST_ISSUE;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            PH_READ: begin
                                remain <= remain - CNT_W'(1);
                                if (!last_rd) begin
                                    state <= ST_ISSUE;
                                end else if (cur_stop) begin
                                    ph    <= PH_STOP;
                                    state <= ST_ISSUE;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            default: begin
                                in_txn <= 1'b0;
                                state  <= ST_IDLE;
                            end
                        endcase
                    end
                end
                default: if (!halted) state <= ST_IDLE;
            endcase
        end
    end

    // R12: an offered command holds until it is taken
    a_r12_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready && !eng_fault) |=>
            (cmd_valid || rx_full) && $stable(cmd_op) && $stable(cmd_data));

    // R11: no read offered without receive space
    a_r11_rx_room: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_op == OP_READ)) |-> !rx_full);

    // R5: a discarded entry produces no command in the following cycle
    a_r5_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
        illegal_err |=> !cmd_valid);
endmodule

// File: rtl/i2c_fmt_sequencer.sv
module i2c_fmt_sequencer
    import i2c_fmt_pkg::*;
#(
    parameter int LVL_W  = 7,
    parameter int WDOG_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               fmt_valid,
    input  logic [ENTRY_W-1:0] fmt_entry,
    input  logic [LVL_W-1:0]   fmt_level,
    output logic               fmt_pop,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [2:0]         cmd_op,
    output logic [BYTE_W-1:0]  cmd_data,
    output logic               cmd_ack,
    input  logic               eng_done,
    input  logic               eng_nack,
    input  logic [BYTE_W-1:0]  eng_rdata,
    input  logic               eng_arb_lost,
    input  logic               eng_bus_timeout,
    input  logic               rx_full,
    input  logic [LVL_W-1:0]   rx_level,
    output logic               rx_push,
    output logic [BYTE_W-1:0]  rx_data,
    output logic [HALT_W-1:0]  halt_events,
    input  logic [HALT_W-1:0]  halt_clear,
    input  logic [WDOG_W-1:0]  nack_wait_limit,
    input  logic [LVL_W-1:0]   rx_thresh,
    input  logic [LVL_W-1:0]   fmt_thresh,
    output logic               irq_rx_wm,
    output logic               irq_fmt_wm,
    output logic               illegal_err,
    output logic               host_idle
);
    logic              illegal, e_stop, e_rd, e_rd_cont, e_nak_ok, nack_set;
    phase_e            first_ph;
    logic [CNT_W-1:0]  len;
    logic [BYTE_W-1:0] e_data;
    bus_op_e           op;

    assign cmd_op = op;

    i2c_fmt_decode u_dec (
        .raw(fmt_entry), .illegal(illegal), .first_ph(first_ph), .len(len),
        .data(e_data), .stop(e_stop), .rd(e_rd), .rd_cont(e_rd_cont), .nak_ok(e_nak_ok)
    );

    i2c_fmt_fsm u_fsm (
        .clk(clk), .rst(rst), .enable(enable), .fmt_valid(fmt_valid),
        .illegal(illegal), .first_ph(first_ph), .len(len), .e_data(e_data),
        .e_stop(e_stop), .e_rd(e_rd), .e_rd_cont(e_rd_cont), .e_nak_ok(e_nak_ok),
        .halted(|halt_events), .eng_fault(eng_arb_lost || eng_bus_timeout),
        .fmt_pop(fmt_pop), .illegal_err(illegal_err), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_op(op), .cmd_data(cmd_data), .cmd_ack(cmd_ack),
        .eng_done(eng_done), .eng_nack(eng_nack), .eng_rdata(eng_rdata),
        .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data),
        .nack_set(nack_set), .host_idle(host_idle)
    );

    i2c_fmt_halt #(.WDOG_W(WDOG_W)) u_halt (
        .clk(clk), .rst(rst), .set_arb(eng_arb_lost), .set_tmo(eng_bus_timeout),
        .set_nack(nack_set), .clr_mask(halt_clear), .wd_limit(nack_wait_limit),
        .halt_q(halt_events)
    );

    i2c_fmt_wmark #(.LVL_W(LVL_W), .ABOVE(1'b1)) u_rx_wm (
        .clk(clk), .rst(rst), .level(rx_level), .thresh(rx_thresh), .irq(irq_rx_wm)
    );

    i2c_fmt_wmark #(.LVL_W(LVL_W), .ABOVE(1'b0)) u_fmt_wm (
        .clk(clk), .rst(rst), .level(fmt_level), .thresh(fmt_thresh), .irq(irq_fmt_wm)
    );

    // R6: nothing is taken from the format queue while halted
    a_r6_no_pop_halted: assert property (@(posedge clk) disable iff (rst)
        (|halt_events) |-> !fmt_pop);

    // R10: a disabled sequencer never pops
    a_r10_disabled_no_pop: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !fmt_pop);
endmodule

// File: tb/i2c_fmt_sequencer_tb.sv
module i2c_fmt_sequencer_tb;
    localparam int LVL_W  = 7;
    localparam int WDOG_W = 16;
    localparam int OPC_START = 0, OPC_RSTART = 1, OPC_WRITE = 2, OPC_READ = 3, OPC_STOP = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic              enable = 1'b0;
    logic              fmt_valid;
    logic [12:0]       fmt_entry;
    logic [LVL_W-1:0]  fmt_level;
    logic              fmt_pop;
    logic              cmd_valid;
    logic              cmd_ready = 1'b0;
    logic [2:0]        cmd_op;
    logic [7:0]        cmd_data;
    logic              cmd_ack;
    logic              eng_done = 1'b0;
    logic              eng_nack = 1'b0;
    logic [7:0]        eng_rdata = 8'h00;
    logic              eng_arb_lost = 1'b0;
    logic              eng_bus_timeout = 1'b0;
    logic              rx_full = 1'b0;
    logic [LVL_W-1:0]  rx_level = '0;
    logic              rx_push;
    logic [7:0]        rx_data;
    logic [3:0]        halt_events;
    logic [3:0]        halt_clear = 4'h0;
    logic [WDOG_W-1:0] nack_wait_limit = 16'd20;
    logic [LVL_W-1:0]  rx_thresh = '0;
    logic [LVL_W-1:0]  fmt_thresh = '0;
    logic              irq_rx_wm, irq_fmt_wm, illegal_err, host_idle;

    i2c_fmt_sequencer #(.LVL_W(LVL_W), .WDOG_W(WDOG_W)) u_dut (
        .clk(clk), .rst(rst), .enable(enable), .fmt_valid(fmt_valid),
        .fmt_entry(fmt_entry), .fmt_level(fmt_level), .fmt_pop(fmt_pop),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .cmd_ack(cmd_ack), .eng_done(eng_done),
        .eng_nack(eng_nack), .eng_rdata(eng_rdata), .eng_arb_lost(eng_arb_lost),
        .eng_bus_timeout(eng_bus_timeout), .rx_full(rx_full), .rx_level(rx_level),
        .rx_push(rx_push), .rx_data(rx_data), .halt_events(halt_events),
        .halt_clear(halt_clear), .nack_wait_limit(nack_wait_limit),
        .rx_thresh(rx_thresh), .fmt_thresh(fmt_thresh), .irq_rx_wm(irq_rx_wm),
        .irq_fmt_wm(irq_fmt_wm), .illegal_err(illegal_err), .host_idle(host_idle)
    );

    // format queue model
    logic [12:0] fq [0:63];
    int fh = 0;
    int ft = 0;
    assign fmt_valid = (ft != fh);
    assign fmt_entry = fq[fh % 64];
    assign fmt_level = LVL_W'(ft - fh);
    always @(posedge clk) if (fmt_pop) fh <= fh + 1;

    int ill_cnt = 0;
    int rx_cnt  = 0;
    always @(posedge clk) begin
        if (illegal_err) ill_cnt <= ill_cnt + 1;
        if (rx_push)     rx_cnt  <= rx_cnt + 1;
    end

    int checks = 0;
    int failures = 0;
    bit done_flag = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [12:0] mk(input bit st, input bit sp, input bit rd,
                                       input bit rc, input bit nk, input logic [7:0] b);
        return {nk, rc, rd, sp, st, b};
    endfunction

    task automatic push(input logic [12:0] e);
        fq[ft % 64] = e;
        ft = ft + 1;
    endtask

    // wait for an offered command, check it, accept it, complete it
    task automatic eng_step(input string req, input int op, input int data, input int ack,
                            input bit nack, input logic [7:0] rdata, input int hold);
        int n = 0;
        while (!cmd_valid && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(req, "cmd_valid", int'(cmd_valid), 1);
        if (!cmd_valid) return;
        chk(req, "cmd_op", int'(cmd_op), op);
        if (data >= 0) chk(req, "cmd_data", int'(cmd_data), data);
        if (ack >= 0)  chk(req, "cmd_ack", int'(cmd_ack), ack);
        if (hold > 0) begin
            repeat (hold) @(negedge clk);
            chk("R12", "held cmd_valid", int'(cmd_valid), 1);
            chk("R12", "held cmd_op", int'(cmd_op), op);
        end
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        @(negedge clk);
        eng_nack  = nack;
        eng_rdata = rdata;
        eng_done  = 1'b1;
        #1;
        if (op == OPC_READ) begin
            chk("R3", "rx_push", int'(rx_push), 1);
            chk("R3", "rx_data", int'(rx_data), int'(rdata));
        end
        @(negedge clk);
        eng_done = 1'b0;
        eng_nack = 1'b0;
    endtask

    task automatic pulse_clear(input logic [3:0] m);
        halt_clear = m;
        @(negedge clk);
        halt_clear = 4'h0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R10", "reset cmd_valid", int'(cmd_valid), 0);
        chk("R7", "reset halt_events", int'(halt_events), 0);
        chk("R10", "reset host_idle", int'(host_idle), 1);
        chk("R9", "reset irq_rx_wm", int'(irq_rx_wm), 0);
        chk("R9", "reset irq_fmt_wm", int'(irq_fmt_wm), 0);
    endtask

    task automatic t_write_rstart;   // R1 R2
        push(mk(1, 0, 0, 0, 0, 8'h50));
        push(mk(1, 0, 0, 0, 0, 8'h51));
        push(mk(0, 1, 0, 0, 0, 8'h52));
        eng_step("R1", OPC_START, -1, -1, 0, 8'h00, 2);
        eng_step("R2", OPC_WRITE, 8'h50, -1, 0, 8'h00, 0);
        eng_step("R1", OPC_RSTART, -1, -1, 0, 8'h00, 0);
        eng_step("R2", OPC_WRITE, 8'h51, -1, 0, 8'h00, 0);
        eng_step("R2", OPC_WRITE, 8'h52, -1, 0, 8'h00, 0);
        eng_step("R2", OPC_STOP, -1, -1, 0, 8'h00, 0);
        @(negedge clk);
        chk("R10", "host_idle after stop", int'(host_idle), 1);
    endtask

    task automatic t_read_256;   // R3 R4
        int base;
        push(mk(1, 0, 0, 0, 0, 8'hA1));
        push(mk(0, 1, 1, 0, 0, 8'h00));
        eng_step("R1", OPC_START, -1, -1, 0, 8'h00, 0);
        eng_step("R2", OPC_WRITE, 8'hA1, -1, 0, 8'h00, 0);
        base = rx_cnt;
        for (int i = 0; i < 256; i++)
            eng_step("R4", OPC_READ, -1, (i == 255) ? 0 : 1, 0, 8'(i * 7), 0);
        eng_step("R4", OPC_STOP, -1, -1, 0, 8'h00, 0);
        chk("R3", "reads for length 0", rx_cnt - base, 256);
    endtask

    task automatic t_read_cont;   // R4
        push(mk(1, 0, 0, 0, 0, 8'h63));
        push(mk(0, 0, 1, 1, 0, 8'h01));
        push(mk(0, 1, 1, 0, 0, 8'h02));
        eng_step("R1", OPC_START, -1, -1, 0, 8'h00, 0);
        eng_step("R2", OPC_WRITE, 8'h63, -1, 0, 8'h00, 0);
        eng_step("R4", OPC_READ, -1, 1, 0, 8'h3C, 0);
        eng_step("R4", OPC_READ, -1, 1, 0, 8'h3D, 0);
        eng_step("R4", OPC_READ, -1, 0, 0, 8'h3E, 0);
        eng_step("R4", OPC_STOP, -1, -1, 0, 8'h00, 0);
    endtask

    task automatic t_illegal;   // R5
        int base = ill_cnt;
        push(mk(0, 1, 1, 1, 0, 8'h05));
        push(mk(1, 0, 1, 0, 1, 8'h03));
        push(mk(1, 1, 0, 0, 0, 8'h7E));
        eng_step("R5", OPC_START, -1, -1, 0, 8'h00, 0);
        chk("R5", "illegal pulses", ill_cnt - base, 2);
        eng_step("R5", OPC_WRITE, 8'h7E, -1, 0, 8'h00, 0);
        eng_step("R5", OPC_STOP, -1, -1, 0, 8'h00, 0);
    endtask

    task automatic t_nack_halt;   // R6 R7 R8
        int seen_valid = 0;
        push(mk(1, 1, 0, 0, 0, 8'hA2));
        eng_step("R6", OPC_START, -1, -1, 0, 8'h00, 0);
        eng_step("R6", OPC_WRITE, 8'hA2, -1, 1, 8'h00, 0);
        chk("R6", "nack halt bit", int'(halt_events), 4);
        push(mk(1, 1, 0, 0, 0, 8'h11));
        repeat (5) begin
            @(negedge clk);
            if (cmd_valid) seen_valid++;
        end
        chk("R6", "no stop or command while halted", seen_valid, 0);
        chk("R6", "entry held in queue", int'(fmt_level), 1);
        chk("R10", "host_idle while halted", int'(host_idle), 0);
        chk("R8", "no timeout yet", int'(halt_events[3]), 0);
        repeat (20) @(negedge clk);
        chk("R8", "unhandled nack timeout", int'(halt_events), 12);
        pulse_clear(4'h4);
        chk("R7", "selective clear", int'(halt_events), 8);
        chk("R7", "still halted", int'(fmt_level), 1);
        pulse_clear(4'h8);
        chk("R7", "all clear", int'(halt_events), 0);
        eng_step("R7", OPC_START, -1, -1, 0, 8'h00, 0);
        eng_step("R7", OPC_WRITE, 8'h11, -1, 0, 8'h00, 0);
        eng_step("R7", OPC_STOP, -1, -1, 0, 8'h00, 0);
    endtask

    task automatic t_nack_suppress;   // R6
        push(mk(1, 1, 0, 0, 1, 8'h33));
        eng_step("R6", OPC_START, -1, -1, 0, 8'h00, 0);
        eng_step("R6", OPC_WRITE, 8'h33, -1, 1, 8'h00, 0);
        chk("R6", "suppressed nack no halt", int'(halt_events), 0);
        eng_step("R6", OPC_STOP, -1, -1, 0, 8'h00, 0);
    endtask

    task automatic t_faults;   // R7
        int n = 0;
        push(mk(1, 1, 0, 0, 0, 8'h22));
        eng_step("R7", OPC_START, -1, -1, 0, 8'h00, 0);
        while (!cmd_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        eng_arb_lost = 1'b1;
        eng_bus_timeout = 1'b1;
        @(negedge clk);
        eng_arb_lost = 1'b0;
        eng_bus_timeout = 1'b0;
        @(negedge clk);
        chk("R7", "fault bits", int'(halt_events), 3);
        chk("R7", "no command after fault", int'(cmd_valid), 0);
        pulse_clear(4'h1);
        chk("R7", "clear arb only", int'(halt_events), 2);
        pulse_clear(4'h2);
        chk("R7", "clear timeout", int'(halt_events), 0);
        chk("R10", "idle after fault cleared", int'(host_idle), 1);
    endtask

    task automatic t_rx_full;   // R11
        int seen = 0;
        rx_full = 1'b1;
        push(mk(1, 0, 0, 0, 0, 8'h61));
        push(mk(0, 1, 1, 0, 0, 8'h01));
        eng_step("R11", OPC_START, -1, -1, 0, 8'h00, 0);
        eng_step("R11", OPC_WRITE, 8'h61, -1, 0, 8'h00, 0);
        repeat (8) begin
            @(negedge clk);
            if (cmd_valid) seen++;
        end
        chk("R11", "read held while full", seen, 0);
        rx_full = 1'b0;
        eng_step("R11", OPC_READ, -1, 0, 0, 8'h9C, 0);
        eng_step("R11", OPC_STOP, -1, -1, 0, 8'h00, 0);
    endtask

    task automatic t_watermark_enable;   // R9 R10
        fmt_thresh = 7'd2;
        rx_thresh  = 7'd5;
        rx_level   = 7'd5;
        repeat (2) @(negedge clk);
        chk("R9", "fmt below threshold", int'(irq_fmt_wm), 1);
        chk("R9", "rx equal threshold", int'(irq_rx_wm), 0);
        rx_level = 7'd6;
        enable = 1'b0;
        push(mk(1, 0, 0, 0, 0, 8'h70));
        push(mk(0, 1, 0, 0, 0, 8'h71));
        repeat (4) @(negedge clk);
        chk("R9", "rx above threshold", int'(irq_rx_wm), 1);
        chk("R9", "fmt at threshold", int'(irq_fmt_wm), 0);
        chk("R10", "disabled keeps entries", int'(fmt_level), 2);
        chk("R10", "disabled no command", int'(cmd_valid), 0);
        enable = 1'b1;
        eng_step("R10", OPC_START, -1, -1, 0, 8'h00, 0);
        eng_step("R10", OPC_WRITE, 8'h70, -1, 0, 8'h00, 0);
        eng_step("R10", OPC_WRITE, 8'h71, -1, 0, 8'h00, 0);
        eng_step("R10", OPC_STOP, -1, -1, 0, 8'h00, 0);
        rx_level = 7'd0;
        fmt_thresh = 7'd0;
    endtask

    task automatic finish_run;
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_rstart();
        t_read_256();
        t_read_cont();
        t_illegal();
        t_nack_halt();
        t_nack_suppress();
        t_faults();
        t_rx_full();
        t_watermark_enable();
        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        finish_run();
    end
endmodule